// File: doc/BRIEF.md
# Temperature Conversion Sequencer

This block decides when the temperature converter runs and how each result reaches the readable temperature register. It holds the working configuration: a shutdown flag, a one-shot request flag and a 2-bit resolution code. At reset it loads that configuration from nonvolatile copies presented on input pins. It then starts exactly one conversion. After that conversion it either keeps converting back to back, or stays idle if the loaded shutdown flag is set. In shutdown, setting the one-shot flag gives a single conversion, and the flag clears itself when that conversion ends.

Conversion length is timed inside the block as `BASE_CYC << res` clock cycles, so each extra bit of resolution doubles the wait. At the end of that window the raw 12-bit two's-complement sample on `conv_data` is captured. It is placed left-justified in a 16-bit word, with the sign in bit 15, and the bits below the selected resolution are forced to zero. Every finished result is reported to the alarm logic with a one-cycle pulse. While the host is reading (`rd_busy` high), the register keeps its old value and the new result waits in a holding register until the read ends.

Top module: `tconv_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, `temp_reg` becomes 16'h0000, `cfg_shdn` and `cfg_res` take the values of `nv_shdn` and `nv_res`, and `cfg_oneshot` becomes 0.
- R2: One conversion always follows reset: `conv_start` is high during the second clock cycle after `rst_n` goes high, whatever the value of `cfg_shdn`.
- R3: `rpt_vld` goes high exactly `BASE_CYC << r` cycles after the cycle in which `conv_start` is high, where r is the resolution code latched at that start (8, 16, 32 or 64 cycles by default).
- R4: The reported and stored result is `{conv_data, 4'b0}` with only its top 9 + r bits kept and every lower bit zero. Codes 0/1/2/3 mean 9/10/11/12 bits, or steps of 0.5/0.25/0.125/0.0625 °C.
- R5: While `cfg_shdn` is 1 and `cfg_oneshot` is 0, no new conversion starts once the power-up conversion has been made.
- R6: A configuration write with shutdown=1 and one-shot=1 makes exactly one conversion. `cfg_oneshot` reads 0 from the cycle in which that conversion's `rpt_vld` is high.
- R7: A write with shutdown=0 stores one-shot as 0, so `cfg_oneshot` is never 1 while `cfg_shdn` is 0.
- R8: In the cycle after any clock edge at which `rd_busy` is high, `temp_reg` is unchanged, yet `rpt_vld` and `rpt_temp` still report each finished result.
- R9: A result held back by `rd_busy` appears on `temp_reg` one clock edge after `rd_busy` is seen low.
- R10: If several results finish during one read, the newest of them is the one committed.
- R11: With `cfg_shdn` = 0, conversions run back to back: successive `conv_start` pulses are `(BASE_CYC << r) + 1` cycles apart, and each pulse lasts one cycle.
- R12: A resolution change written during a conversion changes neither that conversion's length nor its format. `conv_res` holds the latched code for the whole conversion, and the new code applies from the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| nv_shdn | input | 1 | Nonvolatile copy of the shutdown flag, loaded at reset |
| nv_res | input | 2 | Nonvolatile copy of the resolution code, loaded at reset |
| cfg_wr_en | input | 1 | Write strobe for the working configuration |
| cfg_wr_shdn | input | 1 | Shutdown value to write |
| cfg_wr_oneshot | input | 1 | One-shot request value to write |
| cfg_wr_res | input | 2 | Resolution code to write |
| cfg_shdn | output | 1 | Working shutdown flag |
| cfg_oneshot | output | 1 | Working one-shot request flag |
| cfg_res | output | 2 | Working resolution code |
| conv_start | output | 1 | One-cycle pulse that starts the external converter |
| conv_res | output | 2 | Resolution latched for the conversion in progress |
| conv_data | input | 12 | Raw two's-complement sample from the converter |
| conv_busy | output | 1 | High while a conversion window is open |
| rd_busy | input | 1 | Host read in progress; blocks register updates |
| temp_reg | output | 16 | Readable temperature register |
| rpt_vld | output | 1 | One-cycle pulse for each finished result |
| rpt_temp | output | 16 | Formatted result reported to the alarm block |

## Verification
A wrong conversion counter shows as a distance between `conv_start` and `rpt_vld` that differs from `BASE_CYC << r`. This is visible on the first conversion after reset, so the bench measures it for every resolution code. A stale or leaking holding register shows either as `temp_reg` moving while `rd_busy` is high, or as an older value appearing one edge after the read ends. A one-shot flag that fails to clear shows within one conversion time as an extra `conv_start` while the block is in shutdown. A resolution latched at the wrong moment shows as a wrong low-bit mask on the first result after the code is rewritten.

// File: rtl/tconv_pkg.sv
package tconv_pkg;

   // sequencer state: waiting for a start condition, or timing a conversion
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_CONV = 1'b1
   } tconv_state_e;

   // working configuration fields
   typedef struct packed {
      logic       shdn;
      logic       oneshot;
      logic [1:0] res;
   } tconv_cfg_t;

endpackage

// File: rtl/tconv_cfg.sv
module tconv_cfg #(
   parameter int RES_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             nv_shdn,
   input  logic [RES_W-1:0] nv_res,
   input  logic             wr_en,
   input  logic             wr_shdn,
   input  logic             wr_oneshot,
   input  logic [RES_W-1:0] wr_res,
   input  logic             clr_oneshot,
   output logic             shdn,
   output logic             oneshot,
   output logic [RES_W-1:0] res
);

   logic             shdn_q;
   logic             oneshot_q;
   logic [RES_W-1:0] res_q;

   // a one-shot request is only meaningful together with shutdown
   logic oneshot_wr_val;
   assign oneshot_wr_val = wr_oneshot & wr_shdn;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shdn_q    <= nv_shdn;
         res_q     <= nv_res;
         oneshot_q <= 1'b0;
      end else if (wr_en) begin
         shdn_q    <= wr_shdn;
         res_q     <= wr_res;
         oneshot_q <= oneshot_wr_val;
      end else if (clr_oneshot) begin
         oneshot_q <= 1'b0;
      end
   end

   assign shdn    = shdn_q;
   assign oneshot = oneshot_q;
   assign res     = res_q;

   // R7
   oneshot_needs_shdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shdn_q |-> !oneshot_q);

endmodule

// File: rtl/tconv_ctrl.sv
module tconv_ctrl
   import tconv_pkg::*;
#(
   parameter int RES_W    = 2,
   parameter int BASE_CYC = 8,
   parameter int CNT_W    = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_shdn,
   input  logic             cfg_oneshot,
   input  logic [RES_W-1:0] cfg_res,
   output logic             conv_start,
   output logic [RES_W-1:0] conv_res,
   output logic             conv_busy,
   output logic             cap
);

   tconv_state_e     st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             first_q;
   logic             start_q;
   logic [RES_W-1:0] res_q;

   // start condition: power-up conversion, continuous mode, or one-shot request
   logic go;
   assign go = (st_q == ST_IDLE) && (first_q || !cfg_shdn || cfg_oneshot);

   // window length: base count doubled per extra bit of resolution
   logic [CNT_W-1:0] load_v;
   assign load_v = (CNT_W'(BASE_CYC) << cfg_res) - CNT_W'(1);

   assign cap = (st_q == ST_CONV) && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cnt_q   <= '0;
         first_q <= 1'b1;
         start_q <= 1'b0;
         res_q   <= '0;
      end else begin
         start_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (go) begin
                  st_q    <= ST_CONV;
                  cnt_q   <= load_v;
                  res_q   <= cfg_res;
                  first_q <= 1'b0;
                  start_q <= 1'b1;
               end
            end
            ST_CONV: begin
               if (cnt_q == '0) begin
                  st_q <= ST_IDLE;
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign conv_start = start_q;
   assign conv_res   = res_q;
   assign conv_busy  = (st_q == ST_CONV);

   // R3
   no_early_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_CONV && cnt_q != '0) |=> (st_q == ST_CONV));

   // R5
   shdn_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && cfg_shdn && !cfg_oneshot && !first_q) |=> !conv_start);

   // R11
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   // R12
   res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_CONV) |=> $stable(conv_res));

endmodule

// File: rtl/tconv_fmt.sv
module tconv_fmt #(
   parameter int DATA_W   = 12,
   parameter int REG_W    = 16,
   parameter int RES_W    = 2,
   parameter int MIN_BITS = 9
) (
   input  logic [RES_W-1:0]  res,
   input  logic [DATA_W-1:0] raw,
   output logic [REG_W-1:0]  val
);

   localparam int PAD = REG_W - DATA_W;

   // number of significant bits kept from the top of the word
   logic [7:0] keep_n;
   assign keep_n = 8'(MIN_BITS) + 8'(res);

   for (genvar i = 0; i < REG_W; i++) begin : g_bit
      if (i < PAD) begin : g_pad
         assign val[i] = 1'b0;
      end else begin : g_dat
         assign val[i] = raw[i-PAD] & (keep_n >= 8'(REG_W - i));
      end
   end

endmodule

// File: rtl/tconv_store.sv
module tconv_store #(
   parameter int REG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap,
   input  logic [REG_W-1:0] new_val,
   input  logic             rd_busy,
   output logic [REG_W-1:0] temp_reg,
   output logic             rpt_vld,
   output logic [REG_W-1:0] rpt_temp
);

   logic [REG_W-1:0] temp_q;
   logic [REG_W-1:0] hold_q;
   logic             hold_vld_q;
   logic             rpt_vld_q;
   logic [REG_W-1:0] rpt_temp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         temp_q     <= '0;
         hold_q     <= '0;
         hold_vld_q <= 1'b0;
         rpt_vld_q  <= 1'b0;
         rpt_temp_q <= '0;
      end else begin
         rpt_vld_q <= cap;
         if (cap) begin
            rpt_temp_q <= new_val;
            if (rd_busy) begin
               hold_q     <= new_val;
               hold_vld_q <= 1'b1;
            end else begin
               temp_q     <= new_val;
               hold_vld_q <= 1'b0;
            end
         end else if (hold_vld_q && !rd_busy) begin
            temp_q     <= hold_q;
            hold_vld_q <= 1'b0;
         end
      end
   end

   assign temp_reg = temp_q;
   assign rpt_vld  = rpt_vld_q;
   assign rpt_temp = rpt_temp_q;

   // R8
   busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_busy |=> $stable(temp_q));

   // R9
   deferred_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_vld_q && !rd_busy && !cap) |=> (temp_q == $past(hold_q)));

   // R10
   newest_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap && rd_busy) |=> (hold_vld_q && hold_q == rpt_temp_q));

endmodule

// File: rtl/tconv_seq.sv
module tconv_seq
   import tconv_pkg::*;
#(
   parameter int DATA_W   = 12,
   parameter int REG_W    = 16,
   parameter int RES_W    = 2,
   parameter int MIN_BITS = 9,
   parameter int BASE_CYC = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nv_shdn,
   input  logic [RES_W-1:0]  nv_res,
   input  logic              cfg_wr_en,
   input  logic              cfg_wr_shdn,
   input  logic              cfg_wr_oneshot,
   input  logic [RES_W-1:0]  cfg_wr_res,
   output logic              cfg_shdn,
   output logic              cfg_oneshot,
   output logic [RES_W-1:0]  cfg_res,
   output logic              conv_start,
   output logic [RES_W-1:0]  conv_res,
   input  logic [DATA_W-1:0] conv_data,
   output logic              conv_busy,
   input  logic              rd_busy,
   output logic [REG_W-1:0]  temp_reg,
   output logic              rpt_vld,
   output logic [REG_W-1:0]  rpt_temp
);

   localparam int MAX_RES = (1 << RES_W) - 1;
   localparam int MAX_CYC = BASE_CYC << MAX_RES;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   // elaboration-time parameter checks
   if (DATA_W > REG_W) begin : g_bad_width
      $error("tconv_seq: DATA_W must not exceed REG_W");
   end
   if (MIN_BITS + MAX_RES != DATA_W) begin : g_bad_res
      $error("tconv_seq: top resolution code must select all DATA_W bits");
   end
   if (BASE_CYC < 1) begin : g_bad_base
      $error("tconv_seq: BASE_CYC must be at least 1");
   end

   logic             cap;
   logic             clr_oneshot;
   logic [REG_W-1:0] fmt_val;
   tconv_cfg_t       cfg_view;

   assign clr_oneshot = cap;

   tconv_cfg #(
      .RES_W(RES_W)
   ) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .nv_shdn    (nv_shdn),
      .nv_res     (nv_res),
      .wr_en      (cfg_wr_en),
      .wr_shdn    (cfg_wr_shdn),
      .wr_oneshot (cfg_wr_oneshot),
      .wr_res     (cfg_wr_res),
      .clr_oneshot(clr_oneshot),
      .shdn       (cfg_shdn),
      .oneshot    (cfg_oneshot),
      .res        (cfg_res)
   );

   tconv_ctrl #(
      .RES_W   (RES_W),
      .BASE_CYC(BASE_CYC),
      .CNT_W   (CNT_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_shdn   (cfg_shdn),
      .cfg_oneshot(cfg_oneshot),
      .cfg_res    (cfg_res),
      .conv_start (conv_start),
      .conv_res   (conv_res),
      .conv_busy  (conv_busy),
      .cap        (cap)
   );

   tconv_fmt #(
      .DATA_W  (DATA_W),
      .REG_W   (REG_W),
      .RES_W   (RES_W),
      .MIN_BITS(MIN_BITS)
   ) u_fmt (
      .res(conv_res),
      .raw(conv_data),
      .val(fmt_val)
   );

   tconv_store #(
      .REG_W(REG_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap     (cap),
      .new_val (fmt_val),
      .rd_busy (rd_busy),
      .temp_reg(temp_reg),
      .rpt_vld (rpt_vld),
      .rpt_temp(rpt_temp)
   );

   if (RES_W == 2) begin : g_cfg_view
      assign cfg_view = '{shdn: cfg_shdn, oneshot: cfg_oneshot, res: cfg_res};

      // R6
      oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cap && !cfg_wr_en) |=> !cfg_view.oneshot);
   end else begin : g_no_view
      assign cfg_view = '0;
   end

endmodule

// File: tb/tconv_seq_tb.sv
module tconv_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        nv_shdn = 1'b1;
   logic [1:0]  nv_res = 2'd2;
   logic        cfg_wr_en = 1'b0;
   logic        cfg_wr_shdn = 1'b0;
   logic        cfg_wr_oneshot = 1'b0;
   logic [1:0]  cfg_wr_res = 2'd0;
   logic        cfg_shdn;
   logic        cfg_oneshot;
   logic [1:0]  cfg_res;
   logic        conv_start;
   logic [1:0]  conv_res;
   logic [11:0] conv_data = 12'h123;
   logic        conv_busy;
   logic        rd_busy = 1'b0;
   logic [15:0] temp_reg;
   logic        rpt_vld;
   logic [15:0] rpt_temp;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   tconv_seq u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .nv_shdn       (nv_shdn),
      .nv_res        (nv_res),
      .cfg_wr_en     (cfg_wr_en),
      .cfg_wr_shdn   (cfg_wr_shdn),
      .cfg_wr_oneshot(cfg_wr_oneshot),
      .cfg_wr_res    (cfg_wr_res),
      .cfg_shdn      (cfg_shdn),
      .cfg_oneshot   (cfg_oneshot),
      .cfg_res       (cfg_res),
      .conv_start    (conv_start),
      .conv_res      (conv_res),
      .conv_data     (conv_data),
      .conv_busy     (conv_busy),
      .rd_busy       (rd_busy),
      .temp_reg      (temp_reg),
      .rpt_vld       (rpt_vld),
      .rpt_temp      (rpt_temp)
   );

   // {res, raw sample, expected register value}
   localparam logic [29:0] VEC [0:5] = '{
      {2'd3, 12'h190, 16'h1900},
      {2'd0, 12'h19F, 16'h1980},
      {2'd1, 12'hE6F, 16'hE6C0},
      {2'd2, 12'h7FF, 16'h7FE0},
      {2'd3, 12'h801, 16'h8010},
      {2'd0, 12'hFFF, 16'hFF80}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr_cfg(input logic sd, input logic os, input logic [1:0] r);
      cfg_wr_en      = 1'b1;
      cfg_wr_shdn    = sd;
      cfg_wr_oneshot = os;
      cfg_wr_res     = r;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   task automatic wait_start(input string req);
      int n;
      n = 0;
      while (!conv_start && n < 1000) begin
         @(negedge clk);
         n++;
      end
      chk(req, int'(conv_start), 1);
   endtask

   // counts cycles from the current negedge to the next rpt_vld
   task automatic count_rpt(output int n);
      n = 0;
      do begin
         @(negedge clk);
         cfg_wr_en = 1'b0;
         n++;
      end while (!rpt_vld && n < 1000);
   endtask

   task automatic count_starts(input int cyc, output int n);
      n = 0;
      for (int k = 0; k < cyc; k++) begin
         @(negedge clk);
         if (conv_start) n++;
      end
   endtask

   task automatic start_gap(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!conv_start && n < 1000);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int n;
      logic [15:0] old;

      // ---- reset into shutdown, resolution code 2
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 temp_reg", int'(temp_reg), 16'h0000);
      chk("R1 cfg_shdn", int'(cfg_shdn), 1);
      chk("R1 cfg_res", int'(cfg_res), 2);
      chk("R1 cfg_oneshot", int'(cfg_oneshot), 0);
      @(negedge clk);
      chk("R2 power-up start", int'(conv_start), 1);
      count_rpt(n);
      chk("R3 power-up length", n, 32);
      chk("R4 power-up value", int'(temp_reg), 16'h1220);
      count_starts(120, n);
      chk("R5 starts in shutdown", n, 0);

      // ---- vector table: one-shot conversions at every resolution
      for (int v = 0; v < 6; v++) begin
         conv_data = VEC[v][27:16];
         wr_cfg(1'b1, 1'b1, VEC[v][29:28]);
         wait_start("R6 one-shot start");
         count_rpt(n);
         chk("R3 length per res", n, 8 << VEC[v][29:28]);
         chk("R4 formatted value", int'(temp_reg), int'(VEC[v][15:0]));
         chk("R6 one-shot cleared", int'(cfg_oneshot), 0);
         count_starts(80, n);
         chk("R6 single conversion", n, 0);
      end

      // ---- continuous mode, one-shot ignored
      conv_data = 12'h0A5;
      wr_cfg(1'b0, 1'b1, 2'd1);
      chk("R7 one-shot ignored", int'(cfg_oneshot), 0);
      wait_start("R11 continuous start");
      start_gap(n);
      chk("R11 start period", n, 17);
      count_rpt(n);
      chk("R4 continuous value", int'(temp_reg), 16'h0A40);

      // ---- resolution change during a conversion
      conv_data = 12'h35B;
      @(negedge clk);
      wait_start("R12 start");
      cfg_wr_en      = 1'b1;
      cfg_wr_shdn    = 1'b0;
      cfg_wr_oneshot = 1'b0;
      cfg_wr_res     = 2'd3;
      count_rpt(n);
      chk("R12 old length kept", n, 16);
      chk("R12 old format kept", int'(temp_reg), 16'h3580);
      wait_start("R12 next start");
      chk("R12 latched code", int'(conv_res), 3);
      count_rpt(n);
      chk("R12 new length", n, 64);
      chk("R12 new format", int'(temp_reg), 16'h35B0);

      // ---- read in progress blocks updates
      wr_cfg(1'b0, 1'b0, 2'd0);
      count_rpt(n);
      count_rpt(n);
      old = temp_reg;
      conv_data = 12'h100;
      rd_busy = 1'b1;
      count_rpt(n);
      chk("R8 frozen on first", int'(temp_reg), int'(old));
      chk("R8 reported anyway", int'(rpt_temp), 16'h1000);
      conv_data = 12'h2C4;
      count_rpt(n);
      chk("R8 frozen on second", int'(temp_reg), int'(old));
      chk("R8 second report", int'(rpt_temp), 16'h2C00);
      rd_busy = 1'b0;
      @(negedge clk);
      chk("R9 R10 deferred commit", int'(temp_reg), 16'h2C00);

      // ---- reset into continuous mode, code 0
      nv_shdn = 1'b0;
      nv_res  = 2'd0;
      rst_n   = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 reload shdn", int'(cfg_shdn), 0);
      chk("R1 reload res", int'(cfg_res), 0);
      chk("R1 temp cleared", int'(temp_reg), 16'h0000);
      @(negedge clk);
      chk("R2 start after reset", int'(conv_start), 1);
      start_gap(n);
      chk("R11 period code 0", n, 9);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule